// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts what happens inside a processor so that profiling software can see where time goes. It has three counters, each 32 bits wide. One counts clock cycles. The other two each count a single event, picked from a vector of one-cycle event pulses by an 8-bit code. A small register bus reaches one packed control word and all three counters. Software can preload a counter with the negative of a sample period. When that counter wraps from all ones to zero, the block sets a sticky overflow flag. If that counter's interrupt enable is set, the block also raises its single interrupt line.

The run mode is held in a four-state machine: `MODE_OFF_FULL`, `MODE_OFF_DIV`, `MODE_ON_FULL` and `MODE_ON_DIV`. Each state records whether counting is on and whether the cycle counter is slowed by 64. A write to the control word moves the machine to the state named by that write's enable and divide bits. There are four transitions:
- START leaves an OFF state for the matching ON state.
- STOP goes from an ON state back to the matching OFF state.
- SLOW goes from a FULL state to a DIV state.
- FAST goes from a DIV state to a FULL state.

A write that changes both bits makes both transitions at once. A write that changes neither leaves the state where it is.

Top module: `perfmon_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Control bit 0 enables counting, starting on the cycle after the write. While it is 0, all three counters hold their values.
- R3: Writing control bit 1 zeroes both event counters, and writing bit 2 zeroes the cycle counter and restarts the divide-by-64 prescaler. Both bits read back as 0, and a counter reset beats a load or an increment in the same cycle.
- R4: With control bit 3 set, the cycle counter advances once every 64 enabled cycles, and the 6-bit prescaler restarts whenever bit 3 changes value. With bit 3 clear, the cycle counter advances on every enabled cycle.
- R5: Event counter 0 counts pulses on `events[code]`, where code is control bits 19:12, and event counter 1 does the same with control bits 27:20. Code 0xFF counts nothing.
- R6: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow flag on the same edge. The flag bits are: event counter 0 in bit 8, event counter 1 in bit 9, and the cycle counter in bit 10.
- R7: Writing 1 to a flag bit of the control word clears that flag, and writing 0 leaves it as it is. An overflow in the same cycle as a clear leaves the flag set.
- R8: `irq` is the OR, over the three counters, of flag AND interrupt enable. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter. `irq` stays high until the flags are cleared.
- R9: The register map is: address 0 the control word (unused bits read 0), address 1 the cycle counter, address 2 event counter 0 and address 3 event counter 1. A counter write takes priority over that counter's increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register at `bus_addr`, combinational |
| events | input | 256 | Event pulses indexed by event code |
| irq | output | 1 | Overflow interrupt |

## Verification
Two pairs of functions can fall in the same cycle, and both are tested. The first pair is an overflow and a write-one-to-clear of the same flag. The bench preloads event counter 0 with all ones. It then fires the selected event in the very cycle that rewrites the control word with flag bit 8 set, and expects the flag and `irq` to stay high. The second pair is a bus load and an increment: the bench writes a counter while its event pulses every cycle, and expects the loaded value rather than that value plus one. A behavioural reference model follows every edge, and the bench compares the read data and `irq` against it on every cycle.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int NUM_CNT = 3;
    localparam int IDX_EV0 = 0;
    localparam int IDX_EV1 = 1;
    localparam int IDX_CYC = 2;

    localparam int BIT_RUN     = 0;
    localparam int BIT_EV_RST  = 1;
    localparam int BIT_CYC_RST = 2;
    localparam int BIT_DIV     = 3;
    localparam int BIT_IE_LO   = 4;
    localparam int BIT_FLAG_LO = 8;
    localparam int SEL0_LO     = 12;
    localparam int SEL1_LO     = 20;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_CYC  = 2'd1;
    localparam logic [1:0] ADR_EV0  = 2'd2;
    localparam logic [1:0] ADR_EV1  = 2'd3;

    typedef enum logic [1:0] {
        MODE_OFF_FULL = 2'd0,
        MODE_OFF_DIV  = 2'd1,
        MODE_ON_FULL  = 2'd2,
        MODE_ON_DIV   = 2'd3
    } mode_e;

    function automatic logic [1:0] cnt_addr(input int idx);
        case (idx)
            IDX_EV0: cnt_addr = ADR_EV0;
            IDX_EV1: cnt_addr = ADR_EV1;
            default: cnt_addr = ADR_CYC;
        endcase
    endfunction

endpackage

// File: rtl/perfmon_prescale.sv
module perfmon_prescale #(
    parameter int PRE_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run & (&cnt_q);
endmodule

// File: rtl/perfmon_evsel.sv
module perfmon_evsel #(
    parameter int SEL_W  = 8,
    localparam int NUM_EV = 1 << SEL_W
) (
    input  logic [NUM_EV-1:0] events,
    input  logic [SEL_W-1:0]  sel,
    input  logic              run,
    output logic              hit
);
    logic unused_code;
    assign unused_code = &sel;
    assign hit = run & ~unused_code & events[sel];
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             inc,
    output logic [CNT_W-1:0] val,
    output logic             wrap
);
    logic [CNT_W-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (clr) begin
            val_q <= '0;
        end else if (ld) begin
            val_q <= ld_val;
        end else if (inc) begin
            val_q <= val_q + 1'b1;
        end
    end

    assign val  = val_q;
    assign wrap = inc & ~clr & ~ld & (&val_q);
endmodule

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
    import perfmon_pkg::*;
#(
    parameter int SEL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic [31:0]        wdata,
    input  logic [NUM_CNT-1:0] wrap,
    output logic               count_en,
    output logic               div_mode,
    output logic               ev_clr,
    output logic               cyc_clr,
    output logic               pre_clr,
    output logic [NUM_CNT-1:0] ie,
    output logic [NUM_CNT-1:0] flags,
    output logic [SEL_W-1:0]   sel0,
    output logic [SEL_W-1:0]   sel1,
    output logic               irq,
    output logic [31:0]        ctrl_rd
);
    mode_e state, state_n;

    logic [NUM_CNT-1:0] ie_q, flag_q, flag_n, clr_mask;
    logic [SEL_W-1:0]   sel0_q, sel1_q;
    logic               unused_bits;

    assign unused_bits = ^{wdata[31:28], wdata[11], wdata[7]};

    // next-state: START / STOP / SLOW / FAST follow the written bits
    always_comb begin
        state_n = state;
        if (ctrl_wr) begin
            unique case ({wdata[BIT_RUN], wdata[BIT_DIV]})
                2'b00: state_n = MODE_OFF_FULL;
                2'b01: state_n = MODE_OFF_DIV;
                2'b10: state_n = MODE_ON_FULL;
                2'b11: state_n = MODE_ON_DIV;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MODE_OFF_FULL;
        else        state <= state_n;
    end

    always_comb begin
        unique case (state)
            MODE_OFF_FULL: begin count_en = 1'b0; div_mode = 1'b0; end
            MODE_OFF_DIV:  begin count_en = 1'b0; div_mode = 1'b1; end
            MODE_ON_FULL:  begin count_en = 1'b1; div_mode = 1'b0; end
            MODE_ON_DIV:   begin count_en = 1'b1; div_mode = 1'b1; end
        endcase
    end

    assign ev_clr  = ctrl_wr & wdata[BIT_EV_RST];
    assign cyc_clr = ctrl_wr & wdata[BIT_CYC_RST];
    assign pre_clr = cyc_clr | (ctrl_wr & (wdata[BIT_DIV] != div_mode));

    assign clr_mask = ctrl_wr ? wdata[BIT_FLAG_LO +: NUM_CNT] : '0;
    assign flag_n   = (flag_q & ~clr_mask) | wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= '0;
            flag_q <= '0;
            sel0_q <= '0;
            sel1_q <= '0;
        end else begin
            flag_q <= flag_n;
            if (ctrl_wr) begin
                ie_q   <= wdata[BIT_IE_LO +: NUM_CNT];
                sel0_q <= wdata[SEL0_LO +: SEL_W];
                sel1_q <= wdata[SEL1_LO +: SEL_W];
            end
        end
    end

    assign ie    = ie_q;
    assign flags = flag_q;
    assign sel0  = sel0_q;
    assign sel1  = sel1_q;
    assign irq   = |(flag_q & ie_q);

    always_comb begin
        ctrl_rd                          = '0;
        ctrl_rd[BIT_RUN]                 = count_en;
        ctrl_rd[BIT_DIV]                 = div_mode;
        ctrl_rd[BIT_IE_LO +: NUM_CNT]    = ie_q;
        ctrl_rd[BIT_FLAG_LO +: NUM_CNT]  = flag_q;
        ctrl_rd[SEL0_LO +: SEL_W]        = sel0_q;
        ctrl_rd[SEL1_LO +: SEL_W]        = sel1_q;
    end
endmodule

// File: rtl/perfmon_top.sv
module perfmon_top
    import perfmon_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int SEL_W  = 8,
    parameter int PRE_W  = 6,
    localparam int NUM_EV = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_EV-1:0] events,
    output logic              irq
);
    logic                            ctrl_wr;
    logic                            count_en, div_mode;
    logic                            ev_clr, cyc_clr, pre_clr, pre_tick;
    logic [NUM_CNT-1:0]              ie, flags, wrap, inc, clr, ld;
    logic [SEL_W-1:0]                sel0, sel1;
    logic [31:0]                     ctrl_rd;
    logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_val;

    assign ctrl_wr = bus_wr & (bus_addr == ADR_CTRL);

    perfmon_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wdata   (bus_wdata),
        .wrap    (wrap),
        .count_en(count_en),
        .div_mode(div_mode),
        .ev_clr  (ev_clr),
        .cyc_clr (cyc_clr),
        .pre_clr (pre_clr),
        .ie      (ie),
        .flags   (flags),
        .sel0    (sel0),
        .sel1    (sel1),
        .irq     (irq),
        .ctrl_rd (ctrl_rd)
    );

    perfmon_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (pre_clr),
        .run  (count_en & div_mode),
        .tick (pre_tick)
    );

    perfmon_evsel #(.SEL_W(SEL_W)) u_sel0 (
        .events(events), .sel(sel0), .run(count_en), .hit(inc[IDX_EV0])
    );
    perfmon_evsel #(.SEL_W(SEL_W)) u_sel1 (
        .events(events), .sel(sel1), .run(count_en), .hit(inc[IDX_EV1])
    );

    assign inc[IDX_CYC] = count_en & (~div_mode | pre_tick);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        localparam logic [1:0] MY_ADDR = cnt_addr(i);
        assign clr[i] = (i == IDX_CYC) ? cyc_clr : ev_clr;
        assign ld[i]  = bus_wr & (bus_addr == MY_ADDR);

        perfmon_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr[i]),
            .ld    (ld[i]),
            .ld_val(bus_wdata[CNT_W-1:0]),
            .inc   (inc[i]),
            .val   (cnt_val[i]),
            .wrap  (wrap[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CTRL: bus_rdata = ctrl_rd;
            ADR_CYC:  bus_rdata[CNT_W-1:0] = cnt_val[IDX_CYC];
            ADR_EV0:  bus_rdata[CNT_W-1:0] = cnt_val[IDX_EV0];
            ADR_EV1:  bus_rdata[CNT_W-1:0] = cnt_val[IDX_EV1];
        endcase
    end
endmodule

// File: rtl/perfmon_checker.sv
module perfmon_checker
    import perfmon_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SEL_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [1:0]                    bus_addr,
    input logic                          bus_wr,
    input logic [31:0]                   bus_wdata,
    input logic                          irq,
    input logic                          count_en,
    input logic [NUM_CNT-1:0]            flags,
    input logic [NUM_CNT-1:0]            ie,
    input logic [NUM_CNT-1:0]            wrap,
    input logic [SEL_W-1:0]              sel0,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_flag
        assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(ctrl_wr && bus_wdata[BIT_FLAG_LO + i])) |=> flags[i]);
        assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[i] |=> flags[i]);
    end

    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !bus_wr) |=> $stable(cnt_val));

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> |(flags & ie));

    assert_unused_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0 == {SEL_W{1'b1}} && !bus_wr) |=> $stable(cnt_val[IDX_EV0]));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_EV0) |=> (cnt_val[IDX_EV0] == $past(bus_wdata[CNT_W-1:0])));

    assert_cycle_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[BIT_CYC_RST]) |=> (cnt_val[IDX_CYC] == '0));
endmodule

bind perfmon_top perfmon_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_perfmon_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .irq      (irq),
    .count_en (count_en),
    .flags    (flags),
    .ie       (ie),
    .wrap     (wrap),
    .sel0     (sel0),
    .cnt_val  (cnt_val)
);

// File: tb/perfmon_top_bench.sv
`timescale 1ns/1ps
module perfmon_top_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = 32'd0;
    logic [31:0]  bus_rdata;
    logic [255:0] events = '0;
    logic         irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    perfmon_top u_perfmon_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .events(events), .irq(irq)
    );

    // reference model: m_c[0]=event0, m_c[1]=event1, m_c[2]=cycles
    logic [31:0] m_c [3];
    logic [2:0]  m_flag, m_ie;
    logic        m_en, m_div;
    logic [7:0]  m_s0, m_s1;
    int          m_pre;

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: m_read = {4'b0, m_s1, m_s0, 1'b0, m_flag, 1'b0, m_ie, m_div, 2'b00, m_en};
            2'd1: m_read = m_c[2];
            2'd2: m_read = m_c[0];
            default: m_read = m_c[1];
        endcase
    endfunction

    task automatic m_update();
        bit cw, inc0, inc1, inc2;
        logic [2:0] wr_hit, clrv, incv, wrapv;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) m_c[i] = 0;
            m_flag = 0; m_ie = 0; m_en = 0; m_div = 0; m_s0 = 0; m_s1 = 0; m_pre = 0;
            return;
        end
        cw   = bus_wr && bus_addr == 2'd0;
        inc0 = m_en && m_s0 != 8'hFF && events[m_s0];
        inc1 = m_en && m_s1 != 8'hFF && events[m_s1];
        inc2 = m_en && (!m_div || m_pre == 63);
        incv = {inc2, inc1, inc0};
        clrv = {cw && bus_wdata[2], cw && bus_wdata[1], cw && bus_wdata[1]};
        wr_hit = {bus_wr && bus_addr == 2'd1, bus_wr && bus_addr == 2'd3, bus_wr && bus_addr == 2'd2};
        wrapv = 0;
        for (int i = 0; i < 3; i++) begin
            if (clrv[i]) m_c[i] = 0;
            else if (wr_hit[i]) m_c[i] = bus_wdata;
            else if (incv[i]) begin
                if (m_c[i] == 32'hFFFF_FFFF) wrapv[i] = 1;
                m_c[i] = m_c[i] + 1;
            end
        end
        if (cw && (bus_wdata[2] || bus_wdata[3] != m_div)) m_pre = 0;
        else if (m_en && m_div) m_pre = (m_pre + 1) % 64;
        m_flag = (m_flag & ~(cw ? bus_wdata[10:8] : 3'b0)) | wrapv;
        if (cw) begin
            m_en = bus_wdata[0]; m_div = bus_wdata[3]; m_ie = bus_wdata[6:4];
            m_s0 = bus_wdata[19:12]; m_s1 = bus_wdata[27:20];
        end
    endtask

    function automatic string addr_tag(input logic [1:0] a);
        case (a)
            2'd0: addr_tag = "R6";
            2'd1: addr_tag = "R4";
            2'd2: addr_tag = "R5";
            default: addr_tag = "R9";
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [31:0] exp_d;
        logic exp_i;
        exp_d = m_read(bus_addr);
        exp_i = |(m_flag & m_ie);
        n_cmp++;
        if (bus_rdata !== exp_d) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, bus_addr, bus_rdata, exp_d);
        end
        n_cmp++;
        if (irq !== exp_i) begin
            n_bad++;
            $display("FAIL R8 irq actual=%b expected=%b", irq, exp_i);
        end
    endtask

    task automatic step();
        @(posedge clk);
        m_update();
        @(negedge clk);
        compare(addr_tag(bus_addr));
    endtask

    task automatic chk(input string tag);
        compare(tag);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_wdata = 0;
    endtask

    function automatic logic [31:0] cw_word(input bit en, input bit evr, input bit cyr,
        input bit dv, input logic [2:0] ien, input logic [2:0] fclr,
        input logic [7:0] s0, input logic [7:0] s1);
        cw_word = {4'b0, s1, s0, 1'b0, fclr, 1'b0, ien, dv, cyr, evr, en};
    endfunction

    task automatic run_cycles(input int n, input bit rnd);
        for (int k = 0; k < n; k++) begin
            bus_addr = 2'(k);
            if (rnd) events = {8{$urandom}};
            step();
        end
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 4; a++) begin
            bus_addr = 2'(a);
            #0.1;
            chk(tag);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_update();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        read_all("R1");

        // R5 R2: random events on codes 3 and 10
        bus_write(2'd0, cw_word(1, 0, 0, 0, 3'b111, 0, 8'd3, 8'd10));
        run_cycles(60, 1);
        read_all("R5");
        bus_write(2'd0, cw_word(0, 0, 0, 0, 3'b111, 0, 8'd3, 8'd10));
        run_cycles(12, 1);
        read_all("R2");

        // R6 R8: preload near wrap
        bus_write(2'd2, 32'hFFFF_FFF0);
        bus_write(2'd3, 32'hFFFF_FFF8);
        bus_write(2'd1, 32'hFFFF_FFF4);
        events = '1;
        bus_write(2'd0, cw_word(1, 0, 0, 0, 3'b011, 0, 8'd3, 8'd10));
        run_cycles(24, 0);
        read_all("R6");
        read_all("R8");

        // R7: clear only bit 9, then collision on bit 8
        events = '0;
        bus_write(2'd0, cw_word(1, 0, 0, 0, 3'b011, 3'b010, 8'd5, 8'd10));
        read_all("R7");
        bus_write(2'd0, cw_word(1, 0, 0, 0, 3'b011, 3'b111, 8'd5, 8'd10));
        bus_write(2'd2, 32'hFFFF_FFFF);
        events[5] = 1'b1;
        bus_write(2'd0, cw_word(1, 0, 0, 0, 3'b011, 3'b001, 8'd5, 8'd10));
        events[5] = 1'b0;
        read_all("R7");

        // R9: load beats increment
        events = '1;
        bus_write(2'd2, 32'd123);
        read_all("R9");

        // R3: both reset bits while counting
        bus_write(2'd0, cw_word(1, 1, 1, 0, 3'b111, 3'b111, 8'd5, 8'd10));
        read_all("R3");

        // R4: divide-by-64 with mode toggling
        events = '0;
        bus_write(2'd0, cw_word(1, 0, 1, 1, 3'b000, 0, 8'd5, 8'd10));
        run_cycles(200, 0);
        bus_write(2'd0, cw_word(1, 0, 0, 0, 3'b000, 0, 8'd5, 8'd10));
        run_cycles(7, 0);
        bus_write(2'd0, cw_word(1, 0, 0, 1, 3'b000, 0, 8'd5, 8'd10));
        run_cycles(150, 0);
        bus_write(2'd0, cw_word(0, 0, 0, 1, 3'b000, 0, 8'd5, 8'd10));
        run_cycles(70, 0);
        bus_write(2'd0, cw_word(1, 0, 0, 1, 3'b000, 0, 8'd5, 8'd10));
        run_cycles(100, 0);
        read_all("R4");

        // R5: code 0xFF counts nothing
        events = '1;
        bus_write(2'd0, cw_word(1, 0, 0, 0, 3'b111, 0, 8'hFF, 8'hFF));
        run_cycles(20, 0);
        read_all("R5");
        run_cycles(200, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule